// File: doc/BRIEF.md
# DDR4 Command and Address Decoder

This block turns the command and address pins of a DDR4-style memory interface, as sampled on each rising clock edge, into a decoded command. It produces one one-hot command-type vector and the fields that command carries: row, column, bank group, bank, and the three qualifier flags (auto precharge, burst chop, precharge all). It handles chip-select masking. It lets the three command pins double as the top row-address bits when an ACTIVATE is presented. It reads the A10 and A12 pins according to the command that is being decoded.

All outputs leave the block through one register stage, so a command presented before edge N appears on the outputs just after edge N. Downstream logic such as a bank state tracker or a timing checker consumes `cmd_vld` and the one-hot vector. It does not need to know the pin encoding.

Top module: `ddr_cmd_decode`

## Requirements
- R1: When `cs_n` is sampled high, the next outputs show `cmd_vld`=0, `cmd_oh`=0, `cmd_rsvd`=0 and every field output at zero.
- R2: With `cs_n` and `act_n` both sampled low, the block decodes ACTIVATE (`cmd_oh` bit 0) whatever the levels of `ras_n`, `cas_n` and `we_n`. `row_o` equals {`ras_n`,`cas_n`,`we_n`,`addr`}, so those three pins become row bits 16, 15 and 14. `row_o` is zero for every other command.
- R3: With `cs_n` low and `act_n` high, the pattern {`ras_n`,`cas_n`,`we_n`} selects one `cmd_oh` bit and sets `cmd_vld`. The mapping is 101 to READ (bit 1), 100 to WRITE (bit 2), 010 to PRECHARGE (bit 3), 000 to MODE REGISTER SET (bit 4), 001 to REFRESH (bit 5), 011 to the auxiliary refresh/mode class (bit 6) and 111 to NOP (bit 7).
- R4: The pattern 110 with `act_n` high and `cs_n` low is reserved. It gives `cmd_rsvd`=1, `cmd_vld`=0 and `cmd_oh`=0.
- R5: `col_o` equals `addr[9:0]` on READ and WRITE, and is zero for all other commands.
- R6: `bg_o` and `ba_o` copy the bank group and bank inputs on ACTIVATE, READ, WRITE and single-bank PRECHARGE. They are zero otherwise, including PRECHARGE with `addr[10]` high.
- R7: `ap_o` equals `addr[10]` on READ and WRITE and is zero otherwise.
- R8: `bc4_o` equals the inverse of `addr[12]` on READ and WRITE, so A12 low gives a chop of 4. It is zero otherwise.
- R9: `pall_o` equals `addr[10]` on PRECHARGE and is zero otherwise.
- R10: The outputs reflect the inputs sampled at the previous rising edge, with exactly one cycle of latency.
- R11: The synchronous active-high `rst` clears `cmd_vld`, `cmd_oh`, `cmd_rsvd` and every field at the next edge, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge samples |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, low to accept a command |
| act_n | input | 1 | Activate select, low for ACTIVATE |
| ras_n | input | 1 | Command pin, or row bit 16 on ACTIVATE |
| cas_n | input | 1 | Command pin, or row bit 15 on ACTIVATE |
| we_n | input | 1 | Command pin, or row bit 14 on ACTIVATE |
| addr | input | 14 | Address pins A13..A0 |
| bg | input | 2 | Bank group |
| ba | input | 2 | Bank within group |
| cmd_vld | output | 1 | A decoded command is present |
| cmd_oh | output | 8 | One-hot command type |
| cmd_rsvd | output | 1 | Reserved pattern seen |
| row_o | output | 17 | Row address on ACTIVATE |
| col_o | output | 10 | Column address on READ/WRITE |
| bg_o | output | 2 | Decoded bank group |
| ba_o | output | 2 | Decoded bank |
| ap_o | output | 1 | Auto precharge requested |
| bc4_o | output | 1 | Burst chop of 4 requested |
| pall_o | output | 1 | Precharge all banks |

## Verification
The critical collision is an ACTIVATE whose row bits 16..14 happen to spell a READ, WRITE or reserved pattern on the command pins. In that cycle the command decode and the row-bit reuse compete for the same three pins. The stimulus sweeps all eight pin patterns with `act_n` low and then high, back to back, and switches A10 and A12 between commands. A behavioural reference model, compared on every clock, then confirms two things: only the ACTIVATE bit rises, and the row carries the pins, while A10 never leaks into the flags of the wrong command.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;

  localparam int NCMD = 8;

  typedef enum logic [2:0] {
    CK_ACT = 3'd0,
    CK_RD  = 3'd1,
    CK_WR  = 3'd2,
    CK_PRE = 3'd3,
    CK_MRS = 3'd4,
    CK_REF = 3'd5,
    CK_AUX = 3'd6,
    CK_NOP = 3'd7
  } cmd_kind_e;

  // command pin patterns {ras_n, cas_n, we_n} with act_n high
  localparam logic [2:0] PAT_MRS = 3'b000;
  localparam logic [2:0] PAT_REF = 3'b001;
  localparam logic [2:0] PAT_PRE = 3'b010;
  localparam logic [2:0] PAT_AUX = 3'b011;
  localparam logic [2:0] PAT_WR  = 3'b100;
  localparam logic [2:0] PAT_RD  = 3'b101;
  localparam logic [2:0] PAT_RSV = 3'b110;
  localparam logic [2:0] PAT_NOP = 3'b111;

endpackage

// File: rtl/ddr_cmd_classify.sv
module ddr_cmd_classify
  import ddr_cmd_pkg::*;
(
  input  logic      cs_n,
  input  logic      act_n,
  input  logic      ras_n,
  input  logic      cas_n,
  input  logic      we_n,
  output cmd_kind_e kind,
  output logic      hit,
  output logic      rsvd
);

  logic [2:0] pat;
  assign pat = {ras_n, cas_n, we_n};

  always_comb begin
    kind = CK_NOP;
    hit  = 1'b0;
    rsvd = 1'b0;
    if (!cs_n) begin
      if (!act_n) begin
        kind = CK_ACT;
        hit  = 1'b1;
      end else begin
        hit = 1'b1;
        unique case (pat)
          PAT_RD:  kind = CK_RD;
          PAT_WR:  kind = CK_WR;
          PAT_PRE: kind = CK_PRE;
          PAT_MRS: kind = CK_MRS;
          PAT_REF: kind = CK_REF;
          PAT_AUX: kind = CK_AUX;
          PAT_NOP: kind = CK_NOP;
          default: begin
            hit  = 1'b0;
            rsvd = 1'b1;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/ddr_cmd_fields.sv
module ddr_cmd_fields
  import ddr_cmd_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int COL_W  = 10,
  parameter int BG_W   = 2,
  parameter int BA_W   = 2,
  parameter int AP_BIT = 10,
  parameter int BC_BIT = 12,
  localparam int ROW_W = ADDR_W + 3
) (
  input  logic              hit,
  input  cmd_kind_e         kind,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BG_W-1:0]   bg,
  input  logic [BA_W-1:0]   ba,
  output logic [NCMD-1:0]   oh,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col,
  output logic [BG_W-1:0]   bg_o,
  output logic [BA_W-1:0]   ba_o,
  output logic              ap,
  output logic              bc4,
  output logic              pall
);

  for (genvar i = 0; i < NCMD; i++) begin : g_oh
    assign oh[i] = hit && (kind == cmd_kind_e'(i));
  end

  logic is_act, is_rw, is_pre, bank_en;
  assign is_act  = oh[CK_ACT];
  assign is_rw   = oh[CK_RD] | oh[CK_WR];
  assign is_pre  = oh[CK_PRE];
  assign bank_en = is_act | is_rw | (is_pre & ~addr[AP_BIT]);

  always_comb begin
    row  = is_act ? {ras_n, cas_n, we_n, addr} : '0;
    col  = is_rw ? addr[COL_W-1:0] : '0;
    bg_o = bank_en ? bg : '0;
    ba_o = bank_en ? ba : '0;
    ap   = is_rw & addr[AP_BIT];
    bc4  = is_rw & ~addr[BC_BIT];
    pall = is_pre & addr[AP_BIT];
  end

endmodule

// File: rtl/ddr_cmd_outreg.sv
module ddr_cmd_outreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

endmodule

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_cmd_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int COL_W  = 10,
  parameter int BG_W   = 2,
  parameter int BA_W   = 2,
  parameter int AP_BIT = 10,
  parameter int BC_BIT = 12,
  localparam int ROW_W = ADDR_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              act_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BG_W-1:0]   bg,
  input  logic [BA_W-1:0]   ba,
  output logic              cmd_vld,
  output logic [NCMD-1:0]   cmd_oh,
  output logic              cmd_rsvd,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic [BG_W-1:0]   bg_o,
  output logic [BA_W-1:0]   ba_o,
  output logic              ap_o,
  output logic              bc4_o,
  output logic              pall_o
);

  localparam int PKT_W = 2 + NCMD + ROW_W + COL_W + BG_W + BA_W + 3;

  cmd_kind_e             kind;
  logic                  hit, rsvd;
  logic [NCMD-1:0]       oh_c;
  logic [ROW_W-1:0]      row_c;
  logic [COL_W-1:0]      col_c;
  logic [BG_W-1:0]       bg_c;
  logic [BA_W-1:0]       ba_c;
  logic                  ap_c, bc4_c, pall_c;
  logic [PKT_W-1:0]      pkt_d, pkt_q;

  ddr_cmd_classify u_cls (
    .cs_n (cs_n), .act_n(act_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .kind (kind), .hit  (hit),   .rsvd (rsvd)
  );

  ddr_cmd_fields #(
    .ADDR_W(ADDR_W), .COL_W(COL_W), .BG_W(BG_W), .BA_W(BA_W),
    .AP_BIT(AP_BIT), .BC_BIT(BC_BIT)
  ) u_fld (
    .hit (hit),  .kind(kind), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .bg  (bg),   .ba   (ba),
    .oh  (oh_c), .row (row_c), .col (col_c), .bg_o(bg_c), .ba_o(ba_c),
    .ap  (ap_c), .bc4 (bc4_c), .pall(pall_c)
  );

  assign pkt_d = {hit, rsvd, oh_c, row_c, col_c, bg_c, ba_c, ap_c, bc4_c, pall_c};

  ddr_cmd_outreg #(.W(PKT_W)) u_reg (
    .clk(clk), .rst(rst), .d(pkt_d), .q(pkt_q)
  );

  assign {cmd_vld, cmd_rsvd, cmd_oh, row_o, col_o, bg_o, ba_o, ap_o, bc4_o, pall_o} = pkt_q;

  // R1: deselect masks everything
  a_r1_mask: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (!cmd_vld && cmd_oh == '0 && !cmd_rsvd));

  // R2: command pins become row bits under activate
  a_r2_act_row: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !act_n) |=> (cmd_oh[0] && row_o[ROW_W-1 -: 3] == $past({ras_n, cas_n, we_n})));

  // R3: exactly one type bit when valid, none otherwise
  a_r3_onehot: assert property (@(posedge clk) disable iff (rst)
    cmd_vld ? ($countones(cmd_oh) == 1) : (cmd_oh == '0));

  // R4: reserved never coexists with a valid command
  a_r4_rsvd_excl: assert property (@(posedge clk) disable iff (rst)
    cmd_rsvd |-> !cmd_vld);

  // R7: auto precharge only on read or write
  a_r7_ap_rw: assert property (@(posedge clk) disable iff (rst)
    ap_o |-> (cmd_oh[1] || cmd_oh[2]));

  // R8: burst chop only on read or write
  a_r8_bc_rw: assert property (@(posedge clk) disable iff (rst)
    bc4_o |-> (cmd_oh[1] || cmd_oh[2]));

  // R9: precharge-all only on precharge
  a_r9_pall_pre: assert property (@(posedge clk) disable iff (rst)
    pall_o |-> cmd_oh[3]);

endmodule

// File: tb/ddr_cmd_decode_test.sv
module ddr_cmd_decode_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, act_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [13:0] addr = '0;
  logic [1:0]  bg = '0, ba = '0;

  logic        cmd_vld, cmd_rsvd, ap_o, bc4_o, pall_o;
  logic [7:0]  cmd_oh;
  logic [16:0] row_o;
  logic [9:0]  col_o;
  logic [1:0]  bg_o, ba_o;

  int total = 0;
  int bad   = 0;
  bit armed = 1'b0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  ddr_cmd_decode uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .act_n(act_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .addr(addr), .bg(bg), .ba(ba),
    .cmd_vld(cmd_vld), .cmd_oh(cmd_oh), .cmd_rsvd(cmd_rsvd), .row_o(row_o),
    .col_o(col_o), .bg_o(bg_o), .ba_o(ba_o), .ap_o(ap_o), .bc4_o(bc4_o),
    .pall_o(pall_o)
  );

  // behavioural reference
  logic        e_vld, e_rsvd, e_ap, e_bc, e_pall;
  logic [7:0]  e_oh;
  logic [16:0] e_row;
  logic [9:0]  e_col;
  logic [1:0]  e_bg, e_ba;

  always @(posedge clk) begin
    int k;
    k = -1;
    e_vld = 0; e_rsvd = 0; e_ap = 0; e_bc = 0; e_pall = 0;
    e_oh = 0; e_row = 0; e_col = 0; e_bg = 0; e_ba = 0;
    if (!rst && cs_n == 1'b0) begin
      if (act_n == 1'b0) k = 0;
      else begin
        case ({ras_n, cas_n, we_n})
          3'b101: k = 1;
          3'b100: k = 2;
          3'b010: k = 3;
          3'b000: k = 4;
          3'b001: k = 5;
          3'b011: k = 6;
          3'b111: k = 7;
          default: e_rsvd = 1;
        endcase
      end
    end
    if (k >= 0) begin
      e_vld = 1;
      e_oh[k] = 1'b1;
      if (k == 0) begin
        e_row = {ras_n, cas_n, we_n, addr};
        e_bg = bg; e_ba = ba;
      end
      if (k == 1 || k == 2) begin
        e_col = addr[9:0];
        e_bg = bg; e_ba = ba;
        e_ap = addr[10];
        e_bc = !addr[12];
      end
      if (k == 3) begin
        e_pall = addr[10];
        if (!addr[10]) begin e_bg = bg; e_ba = ba; end
      end
    end
    armed <= 1'b1;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (armed && !done) begin
      chk("R1", "vld",  32'(cmd_vld),  32'(e_vld));
      chk("R3", "oh",   32'(cmd_oh),   32'(e_oh));
      chk("R4", "rsvd", 32'(cmd_rsvd), 32'(e_rsvd));
      chk("R2", "row",  32'(row_o),    32'(e_row));
      chk("R5", "col",  32'(col_o),    32'(e_col));
      chk("R6", "bank", 32'({bg_o, ba_o}), 32'({e_bg, e_ba}));
      chk("R7", "ap",   32'(ap_o),     32'(e_ap));
      chk("R8", "bc4",  32'(bc4_o),    32'(e_bc));
      chk("R9", "pall", 32'(pall_o),   32'(e_pall));
    end
  end

  task automatic drive(input logic c, input logic a, input logic [2:0] p,
                       input logic [13:0] ad, input logic [1:0] g, input logic [1:0] b);
    @(negedge clk);
    cs_n = c; act_n = a; {ras_n, cas_n, we_n} = p; addr = ad; bg = g; ba = b;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int unsigned lcg;
    lcg = 32'h1234_5678;
    repeat (3) @(negedge clk);
    #1;
    chk("R11", "reset vld", 32'(cmd_vld), 0);
    chk("R11", "reset oh",  32'(cmd_oh),  0);
    @(negedge clk);
    rst = 1'b0;

    // full sweep: act_n low then high for every pin pattern, A10/A12 toggled
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < 2; a++)
        for (int p = 0; p < 8; p++)
          for (int q = 0; q < 4; q++)
            drive(c[0], a[0], p[2:0],
                  {1'b1, q[1], 1'b0, q[0], 10'h2A5 ^ 10'(p * 37)},
                  2'(p), 2'(q));

    // R10: one-cycle latency of a single read
    drive(1'b0, 1'b1, 3'b101, 14'h0155, 2'd3, 2'd1);
    @(negedge clk);
    #1;
    chk("R10", "read latency oh",  32'(cmd_oh), 32'h2);
    chk("R10", "read latency col", 32'(col_o),  32'h155);
    cs_n = 1'b1;

    // R11: reset during a write overrides the command
    drive(1'b0, 1'b1, 3'b100, 14'h0777, 2'd1, 2'd2);
    rst = 1'b1;
    @(negedge clk);
    #1;
    chk("R11", "reset mid vld", 32'(cmd_vld), 0);
    chk("R11", "reset mid col", 32'(col_o),   0);
    rst = 1'b0;

    // pseudo-random traffic, chip select mostly low
    for (int i = 0; i < 600; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      drive(lcg[31:29] == 3'b000, lcg[28], lcg[27:25], lcg[24:11], lcg[10:9], lcg[8:7]);
    end

    drive(1'b1, 1'b1, 3'b111, '0, '0, '0);
    repeat (2) @(negedge clk);
    #1;
    finish_run();
  end

endmodule